// File: doc/BRIEF.md
# Floating-Point Register Rename Status Table

This block holds the floating-point register file of a tag-based out-of-order core, together with a status word for each register. The status word names the execution station that will produce the register's next value. A value of zero means no write is outstanding. At issue the block looks up both source registers in the same cycle. For each source it returns either the current value with a zero tag, or the tag of the station that will supply the value later.

In the same issue it renames the destination register. It does this by storing the issuing station's tag as that register's pending producer. An older pending producer is simply replaced, so only the newest writer of a register can ever update it. This removes write-after-write and write-after-read conflicts without stalling.

The block also watches the result broadcast bus. A broadcast carries a data word and the tag of the station that produced it. Every register whose status equals that tag takes the data and returns to the ready state. A source lookup that hits a register being filled in that same cycle sees the broadcast data directly.

Top module: `fp_rename_table`

## Requirements
- R1: After reset every register holds value zero with status zero, so every lookup returns value 0 and tag 0.
- R2: A source register whose status is zero returns its stored value and tag 0 in the same cycle as the lookup.
- R3: A source register with a nonzero status returns that status as its tag and a value of 0, unless R10 applies.
- R4: When `issue_valid` is high, `issue_tag` becomes the status of register `dst_idx`, visible from the next cycle. This holds even when that register already had a nonzero status.
- R5: A broadcast (`bus_valid` high, `bus_tag` nonzero) writes `bus_data` into each register whose status equals `bus_tag` and clears that status to zero. Both changes are visible from the next cycle.
- R6: A broadcast leaves unchanged every register whose status differs from `bus_tag`. This includes a register that has been renamed away from the broadcasting tag.
- R7: A bus with `bus_valid` low, or with `bus_tag` equal to zero, changes no register.
- R8: If an issue renames a register in the same cycle that a broadcast fills it, the register takes the broadcast data and its status becomes the new `issue_tag`, not zero.
- R9: When `dst_idx` equals a source index, that source lookup uses the status held before this cycle's rename.
- R10: A source whose nonzero status equals the tag of a valid broadcast in the same cycle returns `bus_data` with tag 0.
- R11: One broadcast fills every register that waits on its tag, not only the first.
- R12: With `issue_valid` low no status changes through issue, whatever `dst_idx` and `issue_tag` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| src_a_idx | input | 3 | First source register index |
| src_b_idx | input | 3 | Second source register index |
| dst_idx | input | 3 | Destination register index |
| issue_tag | input | 4 | Nonzero tag of the issuing station |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | 4 | Tag of the producing station |
| bus_data | input | 64 | Broadcast result value |
| opnd_a_val | output | 64 | First source value (0 while pending) |
| opnd_a_tag | output | 4 | First source producer tag, 0 when ready |
| opnd_b_val | output | 64 | Second source value (0 while pending) |
| opnd_b_tag | output | 4 | Second source producer tag, 0 when ready |

## Verification
Operand lookups are combinational, so the checks for R2, R3, R9 and R10 compare the outputs in the same cycle the indices and bus are driven. The bench samples one time unit after driving, well before the next rising edge. Renames and broadcast writes (R4 to R8, R11, R12) land in the status and value registers at the next rising edge. Their checks therefore look up the affected register in the cycle after the stimulus, before any further stimulus can change it. A bench-side model is advanced once per edge under the same rules and predicts every lookup. It runs through directed corner sequences and then a long pseudo-random sweep over indices, tags and bus traffic.

// File: rtl/rnt_pkg.sv
package rnt_pkg;

    // How a source operand lookup was resolved.
    typedef enum logic [1:0] {
        SRC_READY   = 2'd0,
        SRC_FORWARD = 2'd1,
        SRC_PENDING = 2'd2
    } src_kind_e;

endpackage

// File: rtl/rnt_slot.sv
module rnt_slot #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dst_hit,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] value_q,
    output logic [TAG_W-1:0]  tag_q
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    slot_t s_d, s_q;
    logic  bus_hit;

    always_comb begin
        bus_hit = bus_valid && (bus_tag != '0) && (bus_tag == s_q.tag);
        s_d     = s_q;
        if (bus_hit) begin
            s_d.value = bus_data;
            s_d.tag   = '0;
        end
        if (dst_hit) begin
            s_d.tag = issue_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign value_q = s_q.value;
    assign tag_q   = s_q.tag;

    // R4: a rename always lands the issuing tag
    a_r4_rename_lands: assert property (@(posedge clk) disable iff (!rst_n)
        dst_hit |=> (tag_q == $past(issue_tag)));

    // R5: a matching broadcast fills the value and frees the slot
    a_r5_bus_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_tag != '0 && bus_tag == tag_q && !dst_hit)
        |=> (tag_q == '0) && (value_q == $past(bus_data)));

    // R8: a broadcast and a rename in one cycle keep the new tag
    a_r8_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_tag != '0 && bus_tag == tag_q && dst_hit)
        |=> (value_q == $past(bus_data)) && (tag_q != '0 || $past(issue_tag) == '0));

    // R6, R7: no matching broadcast and no rename leaves the slot alone
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dst_hit && !(bus_valid && bus_tag != '0 && bus_tag == tag_q))
        |=> $stable(tag_q) && $stable(value_q));

endmodule

// File: rtl/rnt_lookup.sv
module rnt_lookup
    import rnt_pkg::*;
#(
    parameter int unsigned NREG   = 8,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic [NREG-1:0][DATA_W-1:0] reg_vals,
    input  logic [NREG-1:0][TAG_W-1:0]  reg_tags,
    input  logic                        bus_valid,
    input  logic [TAG_W-1:0]            bus_tag,
    input  logic [DATA_W-1:0]           bus_data,
    output logic [DATA_W-1:0]           out_val,
    output logic [TAG_W-1:0]            out_tag
);

    src_kind_e         kind;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;

    always_comb begin
        sel_tag = reg_tags[sel_idx];
        sel_val = reg_vals[sel_idx];
        if (sel_tag == '0) begin
            kind = SRC_READY;
        end else if (bus_valid && bus_tag == sel_tag) begin
            kind = SRC_FORWARD;
        end else begin
            kind = SRC_PENDING;
        end
        unique case (kind)
            SRC_READY: begin
                out_val = sel_val;
                out_tag = '0;
            end
            SRC_FORWARD: begin
                out_val = bus_data;
                out_tag = '0;
            end
            default: begin
                out_val = '0;
                out_tag = sel_tag;
            end
        endcase
    end

    // R3: a pending operand never carries a value
    a_r3_pending_no_value: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag != '0) |-> (out_val == '0));

    // R10: a tag being broadcast now is never reported as pending
    a_r10_no_stale_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && out_tag != '0) |-> (out_tag != bus_tag));

endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table #(
    parameter int unsigned NREG   = 8,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] opnd_a_val,
    output logic [TAG_W-1:0]  opnd_a_tag,
    output logic [DATA_W-1:0] opnd_b_val,
    output logic [TAG_W-1:0]  opnd_b_tag
);

    logic [NREG-1:0][DATA_W-1:0] reg_vals;
    logic [NREG-1:0][TAG_W-1:0]  reg_tags;
    logic [NREG-1:0]             dst_hit;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign dst_hit[g] = issue_valid && (dst_idx == IDX_W'(g));

        rnt_slot #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .dst_hit   (dst_hit[g]),
            .issue_tag (issue_tag),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .value_q   (reg_vals[g]),
            .tag_q     (reg_tags[g])
        );
    end

    rnt_lookup #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_look_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_idx   (src_a_idx),
        .reg_vals  (reg_vals),
        .reg_tags  (reg_tags),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_data  (bus_data),
        .out_val   (opnd_a_val),
        .out_tag   (opnd_a_tag)
    );

    rnt_lookup #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_look_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_idx   (src_b_idx),
        .reg_vals  (reg_vals),
        .reg_tags  (reg_tags),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_data  (bus_data),
        .out_val   (opnd_b_val),
        .out_tag   (opnd_b_tag)
    );

    // R12: at most one status entry is renamed per cycle, none when idle
    a_r12_single_rename: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_hit) && (!issue_valid -> dst_hit == '0));

    // R9: the same-cycle rename is not seen by the source lookup
    a_r9_pre_rename: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && src_a_idx == dst_idx && reg_tags[dst_idx] == '0)
        |-> (opnd_a_tag == '0));

endmodule

// File: tb/fp_rename_table_test.sv
module fp_rename_table_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [2:0]  src_a_idx, src_b_idx, dst_idx;
    logic [3:0]  issue_tag;
    logic        bus_valid;
    logic [3:0]  bus_tag;
    logic [63:0] bus_data;
    logic [63:0] opnd_a_val, opnd_b_val;
    logic [3:0]  opnd_a_tag, opnd_b_tag;

    int checks = 0;
    int errors = 0;

    logic [63:0] mval [8];
    logic [3:0]  mtag [8];

    fp_rename_table uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .src_a_idx   (src_a_idx),
        .src_b_idx   (src_b_idx),
        .dst_idx     (dst_idx),
        .issue_tag   (issue_tag),
        .bus_valid   (bus_valid),
        .bus_tag     (bus_tag),
        .bus_data    (bus_data),
        .opnd_a_val  (opnd_a_val),
        .opnd_a_tag  (opnd_a_tag),
        .opnd_b_val  (opnd_b_val),
        .opnd_b_tag  (opnd_b_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic string classify(input logic [2:0] s, input logic bv,
                                       input logic [3:0] bt);
        if (mtag[s] == 4'd0) return "R2";
        if (bv && bt == mtag[s]) return "R10";
        return "R3";
    endfunction

    // Called just after a falling edge; returns just after the next one.
    task automatic cyc(input logic iv, input logic [2:0] sa, input logic [2:0] sb,
                       input logic [2:0] d, input logic [3:0] t, input logic bv,
                       input logic [3:0] bt, input logic [63:0] bd, input string lbl);
        logic [63:0] ev;
        logic [3:0]  et;
        string la, lb;
        issue_valid = iv; src_a_idx = sa; src_b_idx = sb; dst_idx = d;
        issue_tag = t; bus_valid = bv; bus_tag = bt; bus_data = bd;
        #1;
        la = (lbl == "") ? classify(sa, bv, bt) : lbl;
        lb = (lbl == "") ? classify(sb, bv, bt) : lbl;
        if (mtag[sa] == 4'd0) begin ev = mval[sa]; et = 4'd0; end
        else if (bv && bt == mtag[sa]) begin ev = bd; et = 4'd0; end
        else begin ev = 64'd0; et = mtag[sa]; end
        check(la, "a_val", opnd_a_val, ev);
        check(la, "a_tag", 64'(opnd_a_tag), 64'(et));
        if (mtag[sb] == 4'd0) begin ev = mval[sb]; et = 4'd0; end
        else if (bv && bt == mtag[sb]) begin ev = bd; et = 4'd0; end
        else begin ev = 64'd0; et = mtag[sb]; end
        check(lb, "b_val", opnd_b_val, ev);
        check(lb, "b_tag", 64'(opnd_b_tag), 64'(et));
        @(posedge clk);
        for (int r = 0; r < 8; r++) begin
            if (bv && bt != 4'd0 && mtag[r] == bt) begin
                mval[r] = bd;
                mtag[r] = 4'd0;
            end
        end
        if (iv) mtag[d] = t;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        for (int r = 0; r < 8; r++) begin mval[r] = 64'd0; mtag[r] = 4'd0; end
        rst_n = 1'b0; issue_valid = 1'b0; src_a_idx = '0; src_b_idx = '0;
        dst_idx = '0; issue_tag = '0; bus_valid = 1'b0; bus_tag = '0; bus_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int s = 0; s < 8; s++) cyc(0, 3'(s), 3'(7 - s), 0, 0, 0, 0, 0, "R1");

        // R9: source equals destination sees the old (ready) status
        cyc(1, 0, 1, 0, 4'd3, 0, 0, 0, "R9");
        // R4: rename visible next cycle, and overwrite of a pending one
        cyc(1, 0, 0, 0, 4'd5, 0, 0, 0, "R4");
        // R6: broadcast of the superseded tag is ignored
        cyc(0, 0, 0, 0, 0, 1, 4'd3, 64'hDEAD_0003, "R6");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R6");
        // R10: forward on the broadcast of the current producer
        cyc(0, 0, 1, 0, 0, 1, 4'd5, 64'hAAAA_5555_0000_0005, "R10");
        // R5: value landed and status cleared
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5");

        // R11: two registers waiting on one tag
        cyc(1, 2, 3, 2, 4'd7, 0, 0, 0, "R2");
        cyc(1, 2, 3, 3, 4'd7, 0, 0, 0, "R3");
        cyc(0, 1, 1, 0, 0, 1, 4'd7, 64'h0BBB_BBBB_7777_0007, "R2");
        cyc(0, 2, 3, 0, 0, 0, 0, 0, "R11");

        // R7: invalid bus and zero-tag bus change nothing
        cyc(1, 4, 4, 4, 4'd9, 0, 0, 0, "R2");
        cyc(0, 4, 0, 0, 0, 0, 4'd9, 64'h1111_0009, "R7");
        cyc(0, 4, 0, 0, 0, 1, 4'd0, 64'h2222_0000, "R7");
        cyc(0, 4, 0, 0, 0, 0, 0, 0, "R7");

        // R8: rename and fill of the same register in one cycle
        cyc(1, 4, 5, 4, 4'd11, 1, 4'd9, 64'hCCCC_0000_0009_0009, "R10");
        cyc(0, 4, 4, 0, 0, 0, 0, 0, "R8");
        cyc(0, 4, 5, 0, 0, 1, 4'd11, 64'hDDDD_0000_000B_000B, "R10");
        cyc(0, 4, 4, 0, 0, 0, 0, 0, "R8");

        // R12: idle issue with destination and tag set renames nothing
        cyc(0, 5, 6, 5, 4'd6, 0, 0, 0, "R12");
        cyc(0, 5, 6, 6, 4'd2, 0, 0, 0, "R12");
        cyc(0, 5, 6, 0, 0, 0, 0, 0, "R12");

        // Sweep: pseudo-random issue and broadcast traffic against the model
        lf = 32'hACE1_2468;
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] bt;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            bt = lf[20] ? mtag[lf[23:21]] : lf[27:24];
            cyc(lf[0], lf[3:1], lf[6:4], lf[9:7], 4'(lf[13:10] % 15 + 1),
                lf[14], bt, {lf, ~lf}, "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule